// File: doc/BRIEF.md
# Indirect configuration access engine

This block gives a host processor reach into configuration register files that have no direct address of their own. The host sees two 32-bit words on a simple write/read register bus. One is a data word at offset 0x0. The other is a command word at offset 0x4. To write, the host first loads the data word and then writes the command word. The command word names:

- the operation;
- the destination hop;
- a same-chip or far-side select;
- an address space;
- a register offset.

The write to the command word is what launches the operation.

The engine turns each accepted command into one or two requests on a generic request/acknowledge port toward the target register files. Each request is held until it is acknowledged. A circular write is issued twice: once to the local target and once to the far-side target. The host therefore programs both ends with one command. The host polls the command word for completion. The done flag marks the end of any operation. A read is finished only when the done flag and the data-ready flag are both set, and its value is then in the data word. If an acknowledge never arrives, a timeout ends the operation with an error flag, so the host never hangs. A command written while another is still in flight is dropped, and a sticky error flag records that it was dropped.

Top module: `cfg_access_engine`

## Requirements
- R1: After reset both host words read 0 and no target request is raised.
- R2: Command word layout, in bits:
  - [3:0] operation;
  - [5] local select;
  - [15:8] hop ID;
  - [21:16] offset;
  - [23:22] address space.

  A write to offset 0x4 with operation 0 issues one target request with op code 0, carrying the data word, hop, local flag, space and address. On the acknowledge, done (bit 6) is set and data-ready (bit 7) stays 0.
- R3: Operation 1 issues one read request with op code 1. On its acknowledge the returned value is stored in the data word, and done and data-ready are set in the same cycle. Data-ready is never set without done.
- R4: Operation 3 issues two write requests (op code 0) with the same hop, space, address and data. The first has the local flag set and the second has it clear. Done is set only on the second acknowledge.
- R5: Operation 2 (ID assignment) issues one request with op code 2, the data word and the given fields. Done is set on its acknowledge.
- R6: The target address is 8 bits. In space 3 its upper two bits come from the separately programmed `phy_ofs_hi_i`, sampled when the command is accepted. In any other space the upper bits are 0. The space field is passed out unchanged.
- R7: An accepted command clears done, data-ready, busy-error (bit 4) and timeout-error (bit 24) in its accept cycle. The command word reads back the stored fields in place, plus the live status bits. Bits [31:25] read 0.
- R8: A command written while an operation is in flight is ignored: the stored fields are unchanged and no extra request is issued. It sets the busy-error bit 4, which stays set until the next accepted command.
- R9: While a request waits for its acknowledge, the request and all of its fields stay stable.
- R10: If no acknowledge arrives within `TIMEOUT_CYC` request cycles, the request is dropped and done and bit 24 are set. Data-ready stays 0.
- R11: An operation code from 4 to 15 issues no request. Done and bit 24 are set in the cycle after it is accepted.
- R12: Writing the data word while an operation is in flight does not change the data carried by that operation. Reads of the data word return the last value written or captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Host write strobe |
| bus_addr_i | input | 4 | Host byte address (0x0 data, 0x4 command) |
| bus_wdata_i | input | 32 | Host write data |
| bus_rdata_o | output | 32 | Host read data for `bus_addr_i` |
| phy_ofs_hi_i | input | 2 | Upper offset bits for space-3 accesses |
| tgt_req_o | output | 1 | Target request, held until acknowledge |
| tgt_op_o | output | 2 | 0 write, 1 read, 2 ID assignment |
| tgt_hop_o | output | 8 | Destination hop ID |
| tgt_local_o | output | 1 | 1 same-chip target, 0 far side |
| tgt_space_o | output | 2 | Address space |
| tgt_addr_o | output | 8 | Target register address |
| tgt_wdata_o | output | 32 | Data for write and assignment requests |
| tgt_ack_i | input | 1 | Target acknowledge |
| tgt_rdata_i | input | 32 | Target read data, valid with acknowledge |

## Verification
A sequencer stuck in the wrong state shows up at the host as a done flag that never rises, or as a request count per command that differs from the one or two the operation calls for. A lost circular phase shows up as a missing far-side request. A wrong phase order shows up as the local flag flipping in the wrong order between the two acknowledges. A stale status register shows up on the first readback after a new command: that readback still shows old done or ready bits, which must already be clear. Latching the fields late shows up on the target port, where the data, address or high offset bits differ from those present when the command was accepted. It is visible at the first acknowledge.

// File: rtl/cae_pkg.sv
package cae_pkg;
  localparam int WORD_W  = 32;
  localparam int SUB_W   = 4;
  localparam int HOP_W   = 8;
  localparam int SP_W    = 2;
  localparam int OFF_W   = 6;
  localparam int HI_W    = 2;
  localparam int TADDR_W = OFF_W + HI_W;

  localparam int B_BERR = 4;
  localparam int B_LOC  = 5;
  localparam int B_DONE = 6;
  localparam int B_RDY  = 7;
  localparam int B_HOP  = 8;
  localparam int B_OFF  = B_HOP + HOP_W;
  localparam int B_SP   = B_OFF + OFF_W;
  localparam int B_TERR = B_SP + SP_W;

  localparam logic [SUB_W-1:0] SUB_WR   = 4'd0;
  localparam logic [SUB_W-1:0] SUB_RD   = 4'd1;
  localparam logic [SUB_W-1:0] SUB_ASN  = 4'd2;
  localparam logic [SUB_W-1:0] SUB_CIRC = 4'd3;

  localparam logic [1:0] OP_WR = 2'd0;
  localparam logic [1:0] OP_RD = 2'd1;

  localparam logic [SP_W-1:0] SPACE_PHY = 2'b11;

  typedef struct packed {
    logic [SUB_W-1:0] sub;
    logic             loc;
    logic [HOP_W-1:0] hop;
    logic [SP_W-1:0]  space;
  } cmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_BAD} seq_st_e;
endpackage

// File: rtl/cae_cmd_decode.sv
module cae_cmd_decode
  import cae_pkg::*;
(
  input  logic [SUB_W-1:0]   sub_i,
  input  logic               loc_i,
  input  logic [HOP_W-1:0]   hop_i,
  input  logic [SP_W-1:0]    space_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [HI_W-1:0]    phy_hi_i,
  output cmd_t               cmd_o,
  output logic [TADDR_W-1:0] taddr_o,
  output logic               sub_ok_o
);
  always_comb begin
    cmd_o.sub   = sub_i;
    cmd_o.loc   = loc_i;
    cmd_o.hop   = hop_i;
    cmd_o.space = space_i;
    sub_ok_o    = (sub_i <= SUB_CIRC);
    if (space_i == SPACE_PHY) taddr_o = {phy_hi_i, off_i};
    else                      taddr_o = {{HI_W{1'b0}}, off_i};
  end
endmodule

// File: rtl/cae_host_regs.sv
module cae_host_regs
  import cae_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  input  logic              busy_i,
  input  logic              fin_i,
  input  logic              fin_err_i,
  input  logic              rd_cap_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              launch_o,
  output logic [WORD_W-1:0] data_o,
  output logic              done_o,
  output logic              ready_o,
  output logic              berr_o,
  output logic              terr_o
);
  localparam logic [AW-1:0] A_DATA = AW'(0);
  localparam logic [AW-1:0] A_CMD  = AW'(4);
  localparam int HI_FLD = B_TERR - B_HOP;

  logic wr_data, wr_cmd;
  logic [SUB_W-1:0]  sub_q;
  logic              loc_q;
  logic [HI_FLD-1:0] fld_q;
  logic [WORD_W-1:0] data_q;
  logic done_q, rdy_q, berr_q, terr_q;
  logic [WORD_W-1:0] cmd_rb;

  assign wr_data  = bus_wr_i && (bus_addr_i == A_DATA);
  assign wr_cmd   = bus_wr_i && (bus_addr_i == A_CMD);
  assign launch_o = wr_cmd && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0;
      loc_q <= 1'b0;
      fld_q <= '0;
    end else if (launch_o) begin
      sub_q <= bus_wdata_i[SUB_W-1:0];
      loc_q <= bus_wdata_i[B_LOC];
      fld_q <= bus_wdata_i[B_TERR-1:B_HOP];
    end
  end

  // read capture wins over a simultaneous host write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       data_q <= '0;
    else if (rd_cap_i) data_q <= rd_data_i;
    else if (wr_data)  data_q <= bus_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      rdy_q  <= 1'b0;
      berr_q <= 1'b0;
      terr_q <= 1'b0;
    end else if (launch_o) begin
      done_q <= 1'b0;
      rdy_q  <= 1'b0;
      berr_q <= 1'b0;
      terr_q <= 1'b0;
    end else begin
      if (wr_cmd)   berr_q <= 1'b1;
      if (fin_i) begin
        done_q <= 1'b1;
        terr_q <= fin_err_i;
      end
      if (rd_cap_i) rdy_q <= 1'b1;
    end
  end

  always_comb begin
    cmd_rb                   = '0;
    cmd_rb[SUB_W-1:0]        = sub_q;
    cmd_rb[B_BERR]           = berr_q;
    cmd_rb[B_LOC]            = loc_q;
    cmd_rb[B_DONE]           = done_q;
    cmd_rb[B_RDY]            = rdy_q;
    cmd_rb[B_TERR-1:B_HOP]   = fld_q;
    cmd_rb[B_TERR]           = terr_q;
    if (bus_addr_i == A_DATA)     bus_rdata_o = data_q;
    else if (bus_addr_i == A_CMD) bus_rdata_o = cmd_rb;
    else                          bus_rdata_o = '0;
  end

  assign data_o  = data_q;
  assign done_o  = done_q;
  assign ready_o = rdy_q;
  assign berr_o  = berr_q;
  assign terr_o  = terr_q;
endmodule

// File: rtl/cae_seq.sv
module cae_seq
  import cae_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               launch_i,
  input  cmd_t               cmd_i,
  input  logic               sub_ok_i,
  input  logic [TADDR_W-1:0] taddr_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic               busy_o,
  output logic               fin_o,
  output logic               fin_err_o,
  output logic               rd_cap_o,
  output logic [WORD_W-1:0]  rd_data_o,
  output logic               tgt_req_o,
  output logic [1:0]         tgt_op_o,
  output logic [HOP_W-1:0]   tgt_hop_o,
  output logic               tgt_local_o,
  output logic [SP_W-1:0]    tgt_space_o,
  output logic [TADDR_W-1:0] tgt_addr_o,
  output logic [WORD_W-1:0]  tgt_wdata_o,
  input  logic               tgt_ack_i,
  input  logic [WORD_W-1:0]  tgt_rdata_i
);
  localparam int TCNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TCNT_W-1:0] TCNT_LAST = TCNT_W'(TIMEOUT_CYC - 1);

  seq_st_e st_q;
  logic circ_q, phase_q, loc_q;
  logic [1:0]         op_q;
  logic [HOP_W-1:0]   hop_q;
  logic [SP_W-1:0]    sp_q;
  logic [TADDR_W-1:0] addr_q;
  logic [WORD_W-1:0]  wd_q;
  logic [TCNT_W-1:0]  tcnt_q;
  logic ack_hit, tmo, last_ph;

  assign ack_hit = (st_q == ST_REQ) && tgt_ack_i;
  assign tmo     = (st_q == ST_REQ) && !tgt_ack_i && (tcnt_q == TCNT_LAST);
  assign last_ph = !circ_q || phase_q;

  assign busy_o    = (st_q != ST_IDLE);
  assign fin_o     = (ack_hit && last_ph) || tmo || (st_q == ST_BAD);
  assign fin_err_o = tmo || (st_q == ST_BAD);
  assign rd_cap_o  = ack_hit && (op_q == OP_RD);
  assign rd_data_o = tgt_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      circ_q  <= 1'b0;
      phase_q <= 1'b0;
      loc_q   <= 1'b0;
      op_q    <= OP_WR;
      hop_q   <= '0;
      sp_q    <= '0;
      addr_q  <= '0;
      wd_q    <= '0;
      tcnt_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (launch_i) begin
          if (sub_ok_i) begin
            st_q    <= ST_REQ;
            circ_q  <= (cmd_i.sub == SUB_CIRC);
            phase_q <= 1'b0;
            loc_q   <= (cmd_i.sub == SUB_CIRC) ? 1'b1 : cmd_i.loc;
            op_q    <= (cmd_i.sub == SUB_CIRC) ? OP_WR : cmd_i.sub[1:0];
            hop_q   <= cmd_i.hop;
            sp_q    <= cmd_i.space;
            addr_q  <= taddr_i;
            wd_q    <= wdata_i;
            tcnt_q  <= '0;
          end else begin
            st_q <= ST_BAD;
          end
        end
        ST_REQ: begin
          if (ack_hit) begin
            if (last_ph) begin
              st_q <= ST_IDLE;
            end else begin
              // far-side copy of a circular write
              phase_q <= 1'b1;
              loc_q   <= 1'b0;
              tcnt_q  <= '0;
            end
          end else if (tmo) begin
            st_q <= ST_IDLE;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign tgt_req_o   = (st_q == ST_REQ);
  assign tgt_op_o    = op_q;
  assign tgt_hop_o   = hop_q;
  assign tgt_local_o = loc_q;
  assign tgt_space_o = sp_q;
  assign tgt_addr_o  = addr_q;
  assign tgt_wdata_o = wd_q;
endmodule

// File: rtl/cfg_access_engine.sv
module cfg_access_engine
  import cae_pkg::*;
#(
  parameter int AW          = 4,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_wr_i,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic [WORD_W-1:0]  bus_wdata_i,
  output logic [WORD_W-1:0]  bus_rdata_o,
  input  logic [HI_W-1:0]    phy_ofs_hi_i,
  output logic               tgt_req_o,
  output logic [1:0]         tgt_op_o,
  output logic [HOP_W-1:0]   tgt_hop_o,
  output logic               tgt_local_o,
  output logic [SP_W-1:0]    tgt_space_o,
  output logic [TADDR_W-1:0] tgt_addr_o,
  output logic [WORD_W-1:0]  tgt_wdata_o,
  input  logic               tgt_ack_i,
  input  logic [WORD_W-1:0]  tgt_rdata_i
);
  logic busy, fin, fin_err, rd_cap, launch;
  logic done_w, ready_w, berr_w, terr_w, sub_ok;
  logic [WORD_W-1:0]  rd_data, data_w;
  logic [TADDR_W-1:0] taddr;
  cmd_t cmd;

  cae_cmd_decode u_dec (
    .sub_i    (bus_wdata_i[SUB_W-1:0]),
    .loc_i    (bus_wdata_i[B_LOC]),
    .hop_i    (bus_wdata_i[B_OFF-1:B_HOP]),
    .space_i  (bus_wdata_i[B_TERR-1:B_SP]),
    .off_i    (bus_wdata_i[B_SP-1:B_OFF]),
    .phy_hi_i (phy_ofs_hi_i),
    .cmd_o    (cmd),
    .taddr_o  (taddr),
    .sub_ok_o (sub_ok)
  );

  cae_host_regs #(.AW(AW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .busy_i      (busy),
    .fin_i       (fin),
    .fin_err_i   (fin_err),
    .rd_cap_i    (rd_cap),
    .rd_data_i   (rd_data),
    .launch_o    (launch),
    .data_o      (data_w),
    .done_o      (done_w),
    .ready_o     (ready_w),
    .berr_o      (berr_w),
    .terr_o      (terr_w)
  );

  cae_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .cmd_i       (cmd),
    .sub_ok_i    (sub_ok),
    .taddr_i     (taddr),
    .wdata_i     (data_w),
    .busy_o      (busy),
    .fin_o       (fin),
    .fin_err_o   (fin_err),
    .rd_cap_o    (rd_cap),
    .rd_data_o   (rd_data),
    .tgt_req_o   (tgt_req_o),
    .tgt_op_o    (tgt_op_o),
    .tgt_hop_o   (tgt_hop_o),
    .tgt_local_o (tgt_local_o),
    .tgt_space_o (tgt_space_o),
    .tgt_addr_o  (tgt_addr_o),
    .tgt_wdata_o (tgt_wdata_o),
    .tgt_ack_i   (tgt_ack_i),
    .tgt_rdata_i (tgt_rdata_i)
  );
endmodule

// File: rtl/cae_chk.sv
module cae_chk
  import cae_pkg::*;
#(
  parameter int AW          = 4,
  parameter int TIMEOUT_CYC = 64
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_wr_i,
  input logic [AW-1:0]      bus_addr_i,
  input logic               busy_i,
  input logic               launch_i,
  input logic               tgt_req_i,
  input logic               tgt_ack_i,
  input logic               tgt_local_i,
  input logic [TADDR_W-1:0] tgt_addr_i,
  input logic [WORD_W-1:0]  tgt_wdata_i,
  input logic               done_i,
  input logic               ready_i,
  input logic               berr_i,
  input logic               terr_i
);
  localparam int WC_W = $clog2(TIMEOUT_CYC + 2) + 1;
  logic [WC_W-1:0] wait_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     wait_cnt <= '0;
    else if (tgt_req_i && !tgt_ack_i) wait_cnt <= wait_cnt + 1'b1;
    else                             wait_cnt <= '0;
  end

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_req_i && !tgt_ack_i) |=> ((tgt_req_i && $stable(tgt_addr_i) &&
      $stable(tgt_wdata_i) && $stable(tgt_local_i)) || (done_i && terr_i)));

  // R7
  launch_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> (!done_i && !ready_i && !berr_i && !terr_i));

  // R8
  busy_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && (bus_addr_i == AW'(4)) && busy_i) |=> berr_i);

  // R3
  ready_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |-> done_i);

  // R10
  tmo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_cnt <= WC_W'(TIMEOUT_CYC));

  // R1
  req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_req_i |-> busy_i);
endmodule

bind cfg_access_engine cae_chk #(.AW(AW), .TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .busy_i      (busy),
  .launch_i    (launch),
  .tgt_req_i   (tgt_req_o),
  .tgt_ack_i   (tgt_ack_i),
  .tgt_local_i (tgt_local_o),
  .tgt_addr_i  (tgt_addr_o),
  .tgt_wdata_i (tgt_wdata_o),
  .done_i      (done_w),
  .ready_i     (ready_w),
  .berr_i      (berr_w),
  .terr_i      (terr_w)
);

// File: tb/tb_cfg_access_engine.sv
`timescale 1ns/1ps
module tb_cfg_access_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bwr = 1'b0;
  logic [3:0] baddr = 4'd0;
  logic [31:0] bwd = '0, brd;
  logic [1:0] phy_hi = 2'd0;
  logic req, loc, ack = 1'b0;
  logic [1:0] op, sp;
  logic [7:0] hop, taddr;
  logic [31:0] twd, trd;

  int nchk = 0, nerr = 0;
  int lat = 0, m_cnt = 0, lg_total = 0;
  logic [1:0] lg_op[256];
  logic [7:0] lg_hop[256], lg_addr[256];
  logic lg_loc[256];
  logic [1:0] lg_sp[256];
  logic [31:0] lg_wd[256];

  always #10 clk = ~clk;

  cfg_access_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bwr), .bus_addr_i(baddr),
    .bus_wdata_i(bwd), .bus_rdata_o(brd), .phy_ofs_hi_i(phy_hi),
    .tgt_req_o(req), .tgt_op_o(op), .tgt_hop_o(hop), .tgt_local_o(loc),
    .tgt_space_o(sp), .tgt_addr_o(taddr), .tgt_wdata_o(twd),
    .tgt_ack_i(ack), .tgt_rdata_i(trd));

  function automatic logic [31:0] rd_val(logic [7:0] h, logic [7:0] a);
    return 32'hC0DE_0000 | {16'h0, h, a};
  endfunction
  assign trd = rd_val(hop, taddr);

  // target model: acknowledges after lat waiting cycles, logs each request
  always @(negedge clk) begin
    if (!rst_n) begin ack <= 1'b0; m_cnt <= 0; end
    else if (ack) begin ack <= 1'b0; m_cnt <= 0; end
    else if (req) begin
      if (m_cnt >= lat) begin
        ack <= 1'b1;
        lg_op[lg_total[7:0]]   <= op;
        lg_hop[lg_total[7:0]]  <= hop;
        lg_loc[lg_total[7:0]]  <= loc;
        lg_sp[lg_total[7:0]]   <= sp;
        lg_addr[lg_total[7:0]] <= taddr;
        lg_wd[lg_total[7:0]]   <= twd;
        lg_total <= lg_total + 1;
      end else m_cnt <= m_cnt + 1;
    end else m_cnt <= 0;
  end

  function automatic logic [31:0] mkcmd(logic [3:0] s, logic l, logic [7:0] h,
                                        logic [1:0] p, logic [5:0] o);
    return {8'h0, p, o, h, 2'b00, l, 1'b0, s};
  endfunction

  function automatic logic [7:0] exp_addr(logic [1:0] p, logic [5:0] o, logic [1:0] hi);
    return (p == 2'b11) ? {hi, o} : {2'b00, o};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bwr = 1'b1; baddr = a; bwd = d;
    @(negedge clk); bwr = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); baddr = a; #2; d = brd;
  endtask

  task automatic wait_done(output bit ok, output logic [31:0] w);
    ok = 0;
    for (int i = 0; i < 300; i++) begin
      bus_rd(4'h4, w);
      if (w[6]) begin ok = 1; break; end
    end
  endtask

  task automatic run_op(input string tag, input logic [3:0] s, input logic l,
                        input logic [7:0] h, input logic [1:0] p, input logic [5:0] o,
                        input logic [31:0] d, input logic [1:0] hi);
    int base, n_exp;
    bit ok;
    logic [31:0] w, cw, ew, dv;
    logic [7:0] ea;
    base = lg_total;
    cw = mkcmd(s, l, h, p, o);
    ea = exp_addr(p, o, hi);
    bus_wr(4'h0, d);
    phy_hi = hi;
    bus_wr(4'h4, cw);
    wait_done(ok, w);
    chk({tag, " done"}, {31'd0, ok}, 32'd1);
    ew = cw | 32'h40 | ((s == 4'd1) ? 32'h80 : 32'h0);
    chk({tag, " status word"}, w, ew);
    n_exp = (s == 4'd3) ? 2 : 1;
    chk({tag, " request count"}, lg_total - base, n_exp);
    chk({tag, " op"}, {30'd0, lg_op[base[7:0]]}, (s == 4'd3) ? 32'd0 : {28'd0, s});
    chk({tag, " fields"}, {lg_hop[base[7:0]], lg_sp[base[7:0]], lg_loc[base[7:0]], lg_addr[base[7:0]]},
        {h, p, (s == 4'd3) ? 1'b1 : l, ea});
    if (s == 4'd1) begin
      bus_rd(4'h0, dv);
      chk({tag, " read data"}, dv, rd_val(h, ea));
    end else begin
      chk({tag, " write data"}, lg_wd[base[7:0]], d);
    end
    if (s == 4'd3) begin
      chk({tag, " far copy"}, {lg_loc[(base+1)&255], lg_addr[(base+1)&255], lg_hop[(base+1)&255]},
          {1'b0, ea, h});
      chk({tag, " far data"}, lg_wd[(base+1)&255], d);
    end
  endtask

  initial begin
    #(20ns * 200000);
    nchk++; nerr++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] w, d;
    bit ok;
    int base;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    bus_rd(4'h4, w); chk("R1 cmd word", w, 32'h0);
    bus_rd(4'h0, w); chk("R1 data word", w, 32'h0);
    chk("R1 no request", {31'd0, req}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 no request after release", {31'd0, req}, 32'd0);

    run_op("R2", 4'd0, 1'b1, 8'h01, 2'd0, 6'h0D, 32'h1234_5678, 2'b10);
    run_op("R3 R6", 4'd1, 1'b1, 8'h00, 2'd3, 6'h07, 32'h0, 2'b10);
    run_op("R6 ctrl space", 4'd1, 1'b0, 8'h02, 2'd0, 6'h3F, 32'h0, 2'b11);
    run_op("R4", 4'd3, 1'b0, 8'h02, 2'd0, 6'h21, 32'hA5A5_5A5A, 2'b00);
    run_op("R5", 4'd2, 1'b0, 8'h00, 2'd0, 6'h02, 32'h0002_0202, 2'b00);

    // R7 status clears on the accepting edge
    lat = 10;
    bus_wr(4'h4, mkcmd(4'd0, 1'b1, 8'h07, 2'd3, 6'h11));
    bus_rd(4'h4, w);
    chk("R7 cleared status", w, mkcmd(4'd0, 1'b1, 8'h07, 2'd3, 6'h11));
    wait_done(ok, w);
    chk("R7 done later", {31'd0, ok}, 32'd1);

    // R8 command while busy; R9 held request fields
    lat = 20;
    base = lg_total;
    bus_wr(4'h4, mkcmd(4'd1, 1'b1, 8'h01, 2'd0, 6'h03));
    bus_wr(4'h4, mkcmd(4'd0, 1'b0, 8'h55, 2'd0, 6'h09));
    bus_rd(4'h4, w);
    chk("R8 busy error set", {31'd0, w[4]}, 32'd1);
    chk("R8 fields kept", {24'd0, w[15:8]}, 32'h01);
    wait_done(ok, w);
    chk("R8 single request", lg_total - base, 32'd1);
    chk("R8 busy error sticky", {31'd0, w[4]}, 32'd1);
    chk("R9 held fields", {lg_hop[base[7:0]], lg_addr[base[7:0]], 6'd0, lg_op[base[7:0]]},
        {8'h01, 8'h03, 8'h01});
    lat = 0;
    bus_wr(4'h4, mkcmd(4'd0, 1'b1, 8'h00, 2'd0, 6'h01));
    bus_rd(4'h4, w);
    chk("R8 busy error cleared", {31'd0, w[4]}, 32'd0);
    wait_done(ok, w);

    // R12 data word rewritten while busy
    lat = 15;
    base = lg_total;
    bus_wr(4'h0, 32'h1111_2222);
    bus_wr(4'h4, mkcmd(4'd0, 1'b1, 8'h01, 2'd0, 6'h05));
    bus_wr(4'h0, 32'h3333_4444);
    bus_rd(4'h0, d);
    chk("R12 data word readback", d, 32'h3333_4444);
    wait_done(ok, w);
    chk("R12 in-flight data", lg_wd[base[7:0]], 32'h1111_2222);

    // R10 timeout
    lat = 100000;
    base = lg_total;
    bus_wr(4'h4, mkcmd(4'd1, 1'b1, 8'h00, 2'd0, 6'h08));
    wait_done(ok, w);
    chk("R10 done", {31'd0, ok}, 32'd1);
    chk("R10 err set ready clear", {30'd0, w[24], w[7]}, 32'b10);
    chk("R10 request dropped", {31'd0, req}, 32'd0);
    chk("R10 no ack logged", lg_total - base, 32'd0);
    lat = 0;

    // R11 undefined operation
    base = lg_total;
    bus_wr(4'h4, mkcmd(4'd9, 1'b1, 8'h01, 2'd0, 6'h04));
    bus_rd(4'h4, w);
    chk("R11 done and err", {30'd0, w[24], w[6]}, 32'b11);
    chk("R11 no request", lg_total - base, 32'd0);

    // random mix
    for (int k = 0; k < 60; k++) begin
      logic [3:0] s;
      s = 4'($urandom_range(0, 3));
      lat = $urandom_range(0, 4);
      run_op((s == 4'd0) ? "R2 rnd" : (s == 4'd1) ? "R3 rnd" : (s == 4'd2) ? "R5 rnd" : "R4 rnd",
             s, 1'($urandom), 8'($urandom), 2'($urandom), 6'($urandom), $urandom, 2'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule